// File: doc/BRIEF.md
# Unified Relational Comparator

This block compares two vector operands and delivers every relational outcome at once: equal, not-equal, less, less-or-equal, greater and greater-or-equal. It also tests the sign of the first operand. Equality comes from a bank of per-bit XNOR terms that are reduced with AND. All ordering results come from one less-than core, which subtracts and keeps only the sign bit of the difference. Greater-than is the same core with its operands swapped. The two "or-equal" results are inversions of the strict results.

A mode input picks unsigned or two's-complement interpretation. The operand widths are separate parameters. When they match, the operands are compared as numbers. When they differ, the operands follow array rules. They are never equal. Ordering is decided bit by bit from the left over the common left-aligned part, and a shorter operand that matches the leading bits of the longer one counts as the lesser. All results are registered with one cycle of latency and a synchronous active-high reset.

Top module: `relcmp_unit`

## Requirements
- R1: Every output is registered one clock after its inputs. While `rst` is high at a rising edge, all eight outputs are cleared to 0 at that edge.
- R2: For equal widths, `eq` is 1 exactly when every bit of `a` matches the same bit of `b`. `ne` is always the inverse of `eq`.
- R3: For equal widths with `signed_mode`=0, `lt` is 1 exactly when `a` < `b` as unsigned integers.
- R4: For equal widths with `signed_mode`=1, `lt` is 1 exactly when `a` < `b` as two's-complement integers. This includes the most negative value against the most positive value (0x80 < 0x7F at 8 bits).
- R5: `gt` equals "b less than a", `ge` is the inverse of `lt`, and `le` is the inverse of `gt`. Exactly one of `lt`, `eq` and `gt` is 1 after any non-reset cycle.
- R6: With `signed_mode`=1, `neg` equals the most significant bit of `a` and `nonneg` is its inverse. With `signed_mode`=0, both are 0.
- R7: When WA differs from WB, `eq` is 0 and `ne` is 1 for every operand value.
- R8: When WA differs from WB, ordering compares the shorter operand with the top bits of the longer operand as unsigned bit strings, whatever the mode. If those bits are identical, the shorter operand is the lesser (`lt`=1 when `a` is shorter, `gt`=1 when `b` is shorter).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| a | input | WA | First operand |
| b | input | WB | Second operand |
| eq | output | 1 | a equals b |
| ne | output | 1 | a differs from b |
| lt | output | 1 | a less than b |
| le | output | 1 | a less than or equal to b |
| gt | output | 1 | a greater than b |
| ge | output | 1 | a greater than or equal to b |
| neg | output | 1 | a is negative (signed mode only) |
| nonneg | output | 1 | a is zero or positive (signed mode only) |

## Verification
The hardest case to reach is the unequal-width rule in which the shorter operand equals the leading bits of the longer one. Random values seldom land there, and only a second instance with different widths can exercise it. The bench therefore builds a 3-bit against 5-bit instance and sweeps every operand pair in both modes. In the equal-width instance, it places the sign-boundary pairs (0x80 against 0x7F, 0xFF against 0x00) and forced-equal operands between random vectors.

// File: rtl/relcmp_pkg.sv
package relcmp_pkg;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic le;
        logic gt;
        logic ge;
        logic neg;
        logic nonneg;
    } rel_flags_t;

    localparam rel_flags_t REL_FLAGS_CLEAR = '0;

    function automatic int unsigned min_w(input int unsigned x, input int unsigned y);
        return (x < y) ? x : y;
    endfunction

    // one stage of a ripple-borrow subtracter
    function automatic logic fs_diff(input logic x, input logic y, input logic bi);
        return x ^ y ^ bi;
    endfunction

    function automatic logic fs_borrow(input logic x, input logic y, input logic bi);
        return (~x & y) | (~x & bi) | (y & bi);
    endfunction

endpackage

// File: rtl/relcmp_eq.sv
module relcmp_eq #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         match
);
    logic [W-1:0] bit_same;

    for (genvar i = 0; i < W; i++) begin : g_xnor
        assign bit_same[i] = ~(x[i] ^ y[i]);
    end

    assign match = &bit_same;
endmodule

// File: rtl/relcmp_lt_core.sv
module relcmp_lt_core
    import relcmp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sign_ext,
    output logic         less
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] xe;
    logic [XW-1:0] ye;
    logic [XW:0]   borrow;

    assign xe = {sign_ext & x[W-1], x};
    assign ye = {sign_ext & y[W-1], y};
    assign borrow[0] = 1'b0;

    // borrow chain; only the top difference bit is kept
    for (genvar i = 0; i < XW; i++) begin : g_stage
        assign borrow[i+1] = fs_borrow(xe[i], ye[i], borrow[i]);
    end

    assign less = fs_diff(xe[XW-1], ye[XW-1], borrow[XW-1]);
endmodule

// File: rtl/relcmp_unit.sv
module relcmp_unit
    import relcmp_pkg::*;
#(
    parameter int unsigned WA = 8,
    parameter int unsigned WB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          signed_mode,
    input  logic [WA-1:0] a,
    input  logic [WB-1:0] b,
    output logic          eq,
    output logic          ne,
    output logic          lt,
    output logic          le,
    output logic          gt,
    output logic          ge,
    output logic          neg,
    output logic          nonneg
);
    localparam int unsigned CW   = min_w(WA, WB);
    localparam bit          SAME = (WA == WB);

    cmp_mode_e  mode;
    logic [CW-1:0] a_top;
    logic [CW-1:0] b_top;
    logic       use_ext;
    logic       top_match;
    logic       lt_ab;
    logic       lt_ba;
    logic       eq_c;
    logic       lt_c;
    logic       gt_c;
    rel_flags_t nxt;
    rel_flags_t q;

    assign mode    = cmp_mode_e'(signed_mode);
    assign a_top   = a[WA-1 -: CW];
    assign b_top   = b[WB-1 -: CW];
    assign use_ext = SAME && (mode == CMP_SIGNED);

    relcmp_eq #(.W(CW)) u_eq (
        .x     (a_top),
        .y     (b_top),
        .match (top_match)
    );

    relcmp_lt_core #(.W(CW)) u_lt_ab (
        .x        (a_top),
        .y        (b_top),
        .sign_ext (use_ext),
        .less     (lt_ab)
    );

    relcmp_lt_core #(.W(CW)) u_lt_ba (
        .x        (b_top),
        .y        (a_top),
        .sign_ext (use_ext),
        .less     (lt_ba)
    );

    if (SAME) begin : g_same
        assign eq_c = top_match;
        assign lt_c = lt_ab;
        assign gt_c = lt_ba;
    end else if (WA < WB) begin : g_a_short
        assign eq_c = 1'b0;
        assign lt_c = lt_ab | top_match;
        assign gt_c = lt_ba;
    end else begin : g_b_short
        assign eq_c = 1'b0;
        assign lt_c = lt_ab;
        assign gt_c = lt_ba | top_match;
    end

    always_comb begin
        nxt        = REL_FLAGS_CLEAR;
        nxt.eq     = eq_c;
        nxt.ne     = ~eq_c;
        nxt.lt     = lt_c;
        nxt.ge     = ~lt_c;
        nxt.gt     = gt_c;
        nxt.le     = ~gt_c;
        nxt.neg    = (mode == CMP_SIGNED) &  a[WA-1];
        nxt.nonneg = (mode == CMP_SIGNED) & ~a[WA-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= REL_FLAGS_CLEAR;
        else     q <= nxt;
    end

    assign eq     = q.eq;
    assign ne     = q.ne;
    assign lt     = q.lt;
    assign le     = q.le;
    assign gt     = q.gt;
    assign ge     = q.ge;
    assign neg    = q.neg;
    assign nonneg = q.nonneg;
endmodule

// File: rtl/relcmp_checks.sv
module relcmp_checks #(
    parameter int unsigned WA = 8,
    parameter int unsigned WB = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          signed_mode,
    input logic [WA-1:0] a,
    input logic [WB-1:0] b,
    input logic          eq,
    input logic          ne,
    input logic          lt,
    input logic          le,
    input logic          gt,
    input logic          ge,
    input logic          neg,
    input logic          nonneg
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !(eq | ne | lt | le | gt | ge | neg | nonneg));

    assert_one_order_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($countones({lt, eq, gt}) == 1));

    assert_sign_flag_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (neg == ($past(signed_mode) && $past(a[WA-1])))
              && (nonneg == ($past(signed_mode) && !$past(a[WA-1]))));

    if (WA == WB) begin : g_same
        assert_bit_equal_R2: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (eq == ($past(a) == $past(b))) && (ne != eq));

        assert_unsigned_lt_R3: assert property (@(posedge clk) disable iff (rst)
            (!rst && !signed_mode) |=> (lt == ($past(a) < $past(b))));

        assert_signed_lt_R4: assert property (@(posedge clk) disable iff (rst)
            (!rst && signed_mode) |=> (lt == ($signed($past(a)) < $signed($past(b)))));
    end else begin : g_diff
        assert_never_equal_R7: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (!eq && ne));
    end
endmodule

bind relcmp_unit relcmp_checks #(.WA(WA), .WB(WB)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .signed_mode (signed_mode),
    .a           (a),
    .b           (b),
    .eq          (eq),
    .ne          (ne),
    .lt          (lt),
    .le          (le),
    .gt          (gt),
    .ge          (ge),
    .neg         (neg),
    .nonneg      (nonneg)
);

// File: tb/relcmp_unit_test.sv
module relcmp_unit_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic smode;
    logic [7:0] a8, b8;
    logic [2:0] am;
    logic [4:0] bm;
    logic [7:0] f8;
    logic [7:0] fm;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic eq8, ne8, lt8, le8, gt8, ge8, ng8, nn8;
    logic eqm, nem, ltm, lem, gtm, gem, ngm, nnm;

    always #(CLK_PERIOD/2) clk = ~clk;

    relcmp_unit #(.WA(8), .WB(8)) uut (
        .clk(clk), .rst(rst), .signed_mode(smode), .a(a8), .b(b8),
        .eq(eq8), .ne(ne8), .lt(lt8), .le(le8), .gt(gt8), .ge(ge8),
        .neg(ng8), .nonneg(nn8)
    );

    relcmp_unit #(.WA(3), .WB(5)) uut_mix (
        .clk(clk), .rst(rst), .signed_mode(smode), .a(am), .b(bm),
        .eq(eqm), .ne(nem), .lt(ltm), .le(lem), .gt(gtm), .ge(gem),
        .neg(ngm), .nonneg(nnm)
    );

    assign f8 = {eq8, ne8, lt8, le8, gt8, ge8, ng8, nn8};
    assign fm = {eqm, nem, ltm, lem, gtm, gem, ngm, nnm};

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sv8(input logic [7:0] v, input logic s);
        return (s && v[7]) ? int'(v) - 256 : int'(v);
    endfunction

    task automatic step(input logic r, input logic s, input logic [7:0] x, input logic [7:0] y,
                        input logic [2:0] xm, input logic [4:0] ym);
        int ia, ib, top;
        logic e_lt, e_gt, m_lt, m_gt;
        rst = r; smode = s; a8 = x; b8 = y; am = xm; bm = ym;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            chk("R1", "wide flags", |f8, 1'b0);
            chk("R1", "mixed flags", |fm, 1'b0);
        end else begin
            ia = sv8(x, s); ib = sv8(y, s);
            e_lt = (ia < ib); e_gt = (ib < ia);
            chk("R2", "eq", eq8, x == y);
            chk("R2", "ne", ne8, x != y);
            chk(s ? "R4" : "R3", "lt", lt8, e_lt);
            chk("R5", "gt", gt8, e_gt);
            chk("R5", "ge", ge8, !e_lt);
            chk("R5", "le", le8, !e_gt);
            chk("R6", "neg", ng8, s && x[7]);
            chk("R6", "nonneg", nn8, s && !x[7]);
            top = int'(ym) >> 2;
            m_lt = (int'(xm) <= top); m_gt = (top < int'(xm));
            chk("R7", "mix eq", eqm, 1'b0);
            chk("R7", "mix ne", nem, 1'b1);
            chk("R8", "mix lt", ltm, m_lt);
            chk("R8", "mix gt", gtm, m_gt);
            chk("R5", "mix ge", gem, !m_lt);
            chk("R5", "mix le", lem, !m_gt);
            chk("R6", "mix neg", ngm, s && xm[2]);
            chk("R6", "mix nonneg", nnm, s && !xm[2]);
        end
    endtask

    initial begin
        rst = 1'b1; smode = 1'b0; a8 = '0; b8 = '0; am = '0; bm = '0;
        @(negedge clk);
        step(1'b1, 1'b0, 8'h00, 8'h00, 3'd0, 5'd0);   // R1 reset state
        // R4 / R3 sign boundary and equality corners
        step(1'b0, 1'b1, 8'h80, 8'h7F, 3'd4, 5'd16);
        step(1'b0, 1'b0, 8'h80, 8'h7F, 3'd4, 5'd19);
        step(1'b0, 1'b1, 8'hFF, 8'h00, 3'd7, 5'd31);
        step(1'b0, 1'b0, 8'hFF, 8'h00, 3'd0, 5'd0);
        step(1'b0, 1'b1, 8'h5A, 8'h5A, 3'd3, 5'd12);
        step(1'b0, 1'b0, 8'h00, 8'h00, 3'd7, 5'd28);
        // R1 reset while operands are busy
        step(1'b1, 1'b1, 8'h01, 8'hF0, 3'd5, 5'd9);
        // R8 exhaustive sweep of the mixed-width instance, both modes
        for (int s = 0; s < 2; s++)
            for (int x = 0; x < 8; x++)
                for (int y = 0; y < 32; y++) begin
                    logic [7:0] ra, rb;
                    ra = 8'($urandom);
                    rb = ((x + y) % 5 == 0) ? ra : 8'($urandom);
                    step(1'b0, s[0], ra, rb, x[2:0], y[4:0]);
                end
        // R2..R5 random wide vectors with forced-equal pairs
        for (int k = 0; k < 600; k++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = (k % 7 == 0) ? ra : 8'($urandom);
            step(1'b0, 1'($urandom), ra, rb, 3'($urandom), 5'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule